// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies an unsigned multiplier `a` of `N1` bits by an unsigned multiplicand `b` of `N2` bits and presents the full `N1+N2`-bit product with no clock. It has no registers, so it drops into a datapath wherever one stage of logic delay is acceptable. Because it is purely combinational, it has no valid/ready handshake and no back-pressure: the product follows the operands.

Each bit `a[i]` gates a copy of `b` into a partial-product row that sits `i` columns to the left. The first three rows pass through one 3:2 level, and each later row joins the two surviving rows in a further 3:2 level. A level works column by column. A lone bit drops straight through, a pair goes into a half adder and a triple goes into a full adder. Each sum bit stays in its own column and each carry moves one column up. After the last level only two rows remain, and a ripple carry-propagate adder adds them. Every adder is an explicit half-adder or full-adder cell, and no behavioural multiply appears anywhere in the datapath.

Top module: `mult_csa`

## Requirements
- R1: For every pair of unsigned operands, `product` equals `a*b`, read as an unsigned value of `N1+N2` bits.
- R2: When either operand is zero, `product` is zero.
- R3: When both operands are all ones, `product` equals `(2^N1-1)*(2^N2-1)`.
- R4: When `a` has only bit `i` set, `product` equals `b` shifted left by `i`. Each multiplier bit therefore places one copy of `b` in its own column offset.
- R5: Each 3:2 level keeps the arithmetic total of its three input rows. Its sum row plus twice its carry row equals the sum of its inputs.
- R6: No carry leaves the most significant column of any 3:2 level or of the final adder.
- R7: The block gives correct products when the operand widths differ (for example 8x5, 2x4 and 12x10), including a build with only two partial-product rows, where no 3:2 level is present.
- R8: The product depends only on the present operands. It is correct in the same cycle that the operands are applied and keeps no state from earlier operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N1 | Unsigned multiplier; bit i selects partial-product row i |
| b | input | N2 | Unsigned multiplicand |
| product | output | N1+N2 | Unsigned product a*b |

## Verification
The hardest case to reach is a level in which a full adder in the highest occupied column takes three ones and its carry moves into the column above. This case also tests whether the final adder's carry chain runs the full width without losing a bit. It occurs only when nearly all operand bits are one, so the operands must be chosen deliberately. At 6x6, 8x5 and 2x4 the bench applies every operand pair, so these dense patterns are included. At 12x10 it adds explicit all-ones, zero and single-bit operands to random pairs. The operands change every cycle, so any state left over from the previous pair would show up as a wrong product.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;

  typedef struct packed {
    int s_lo;
    int s_hi;
    int c_lo;
    int c_hi;
  } lvl_rng_t;

  function automatic int min3(int p, int q, int r);
    int m;
    m = (p < q) ? p : q;
    return (m < r) ? m : r;
  endfunction

  function automatic int max3(int p, int q, int r);
    int m;
    m = (p > q) ? p : q;
    return (m > r) ? m : r;
  endfunction

  function automatic int mid3(int p, int q, int r);
    return p + q + r - min3(p, q, r) - max3(p, q, r);
  endfunction

  function automatic int clip(int v, int pw);
    return (v > pw - 1) ? pw - 1 : v;
  endfunction

  // Occupied column span of the sum and carry rows leaving level k.
  function automatic lvl_rng_t lvl_range(int k, int n2, int pw);
    lvl_rng_t r;
    int xl, xh, yl, yh, zl, zh;
    xl = 0; xh = n2 - 1; yl = 1; yh = n2;
    r = '0;
    for (int j = 0; j <= k; j++) begin
      zl = j + 2;
      zh = j + 1 + n2;
      r.s_lo = min3(xl, yl, zl);
      r.s_hi = clip(max3(xh, yh, zh), pw);
      r.c_lo = mid3(xl, yl, zl) + 1;
      r.c_hi = clip(mid3(xh, yh, zh) + 1, pw);
      xl = r.s_lo; xh = r.s_hi; yl = r.c_lo; yh = r.c_hi;
    end
    return r;
  endfunction

endpackage

// File: rtl/mul_ha.sv
module mul_ha (
  input  logic x,
  input  logic y,
  output logic s,
  output logic co
);
  assign s  = x ^ y;
  assign co = x & y;
endmodule

// File: rtl/mul_fa.sv
module mul_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (ci & (x ^ y));
endmodule

// File: rtl/csa_pp_gen.sv
module csa_pp_gen #(
  parameter int N1 = 6,
  parameter int N2 = 6,
  parameter int PW = N1 + N2
) (
  input  logic [N1-1:0]          a,
  input  logic [N2-1:0]          b,
  output logic [N1-1:0][PW-1:0]  rows
);
  for (genvar i = 0; i < N1; i++) begin : g_row
    logic [N2-1:0] gated;
    assign gated   = b & {N2{a[i]}};
    assign rows[i] = PW'(gated) << i;
  end
endmodule

// File: rtl/csa_level.sv
module csa_level #(
  parameter int PW   = 12,
  parameter int X_LO = 0,
  parameter int X_HI = 5,
  parameter int Y_LO = 1,
  parameter int Y_HI = 6,
  parameter int Z_LO = 2,
  parameter int Z_HI = 7
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  input  logic [PW-1:0] z,
  output logic [PW-1:0] s,
  output logic [PW-1:0] c
);
  logic [PW-1:0] cout;

  for (genvar col = 0; col < PW; col++) begin : g_col
    localparam int HX  = (col >= X_LO && col <= X_HI) ? 1 : 0;
    localparam int HY  = (col >= Y_LO && col <= Y_HI) ? 1 : 0;
    localparam int HZ  = (col >= Z_LO && col <= Z_HI) ? 1 : 0;
    localparam int CNT = HX + HY + HZ;
    if (CNT == 3) begin : g_full
      mul_fa fa_i (.x(x[col]), .y(y[col]), .ci(z[col]), .s(s[col]), .co(cout[col]));
    end else if (CNT == 2) begin : g_half
      logic p, q;
      assign p = (HX == 1) ? x[col] : y[col];
      assign q = (HZ == 1) ? z[col] : y[col];
      mul_ha ha_i (.x(p), .y(q), .s(s[col]), .co(cout[col]));
    end else if (CNT == 1) begin : g_pass
      assign s[col]    = (HX == 1) ? x[col] : ((HY == 1) ? y[col] : z[col]);
      assign cout[col] = 1'b0;
    end else begin : g_empty
      assign s[col]    = 1'b0;
      assign cout[col] = 1'b0;
    end
  end

  assign c = {cout[PW-2:0], 1'b0};

  logic [PW+1:0] in_total, out_total;
  always_comb begin
    in_total  = {2'b00, x} + {2'b00, y} + {2'b00, z};
    out_total = {2'b00, s} + {1'b0, cout, 1'b0};
    assert_level_sum_R5: assert (in_total == out_total)
      else $error("3:2 level lost value");
    assert_level_top_carry_R6: assert (cout[PW-1] == 1'b0)
      else $error("carry left top column of a level");
  end
endmodule

// File: rtl/csa_cpa.sv
module csa_cpa #(
  parameter int PW = 12
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  output logic [PW-1:0] s
);
  logic [PW:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < PW; i++) begin : g_bit
    mul_fa fa_i (.x(x[i]), .y(y[i]), .ci(carry[i]), .s(s[i]), .co(carry[i+1]));
  end

  always_comb begin
    assert_cpa_top_carry_R6: assert (carry[PW] == 1'b0)
      else $error("carry left final adder");
  end
endmodule

// File: rtl/mult_csa.sv
module mult_csa
  import csa_mul_pkg::*;
#(
  parameter int N1 = 6,
  parameter int N2 = 6
) (
  input  logic [N1-1:0]    a,
  input  logic [N2-1:0]    b,
  output logic [N1+N2-1:0] product
);
  localparam int PW     = N1 + N2;
  localparam int LEVELS = (N1 > 2) ? N1 - 2 : 1;

  logic [N1-1:0][PW-1:0] rows;

  csa_pp_gen #(.N1(N1), .N2(N2), .PW(PW)) pp_i (.a(a), .b(b), .rows(rows));

  if (N1 == 1) begin : g_one
    assign product = rows[0];
  end else if (N1 == 2) begin : g_two
    csa_cpa #(.PW(PW)) cpa_i (.x(rows[0]), .y(rows[1]), .s(product));
  end else begin : g_tree
    logic [PW-1:0] acc_s [LEVELS];
    logic [PW-1:0] acc_c [LEVELS];

    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
      if (k == 0) begin : g_first
        csa_level #(
          .PW(PW),
          .X_LO(0), .X_HI(N2 - 1),
          .Y_LO(1), .Y_HI(N2),
          .Z_LO(2), .Z_HI(N2 + 1)
        ) lvl_i (
          .x(rows[0]), .y(rows[1]), .z(rows[2]),
          .s(acc_s[0]), .c(acc_c[0])
        );
      end else begin : g_next
        localparam lvl_rng_t PR = lvl_range(k - 1, N2, PW);
        csa_level #(
          .PW(PW),
          .X_LO(PR.s_lo), .X_HI(PR.s_hi),
          .Y_LO(PR.c_lo), .Y_HI(PR.c_hi),
          .Z_LO(k + 2),   .Z_HI(k + 1 + N2)
        ) lvl_i (
          .x(acc_s[k-1]), .y(acc_c[k-1]), .z(rows[k+2]),
          .s(acc_s[k]), .c(acc_c[k])
        );
      end
    end

    csa_cpa #(.PW(PW)) cpa_i (.x(acc_s[LEVELS-1]), .y(acc_c[LEVELS-1]), .s(product));
  end

  always_comb begin
    assert_zero_operand_R2: assert (!(a == '0 || b == '0) || product == '0)
      else $error("zero operand gave nonzero product");
  end
endmodule

// File: tb/mult_csa_tb_top.sv
module mult_csa_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [5:0]  a6, b6;   logic [11:0] p6;
  logic [7:0]  a8;       logic [4:0]  b5;  logic [12:0] p85;
  logic [1:0]  a2;       logic [3:0]  b4;  logic [5:0]  p24;
  logic [11:0] a12;      logic [9:0]  b10; logic [21:0] p1210;

  mult_csa #(.N1(6),  .N2(6))  dut_i   (.a(a6),  .b(b6),  .product(p6));
  mult_csa #(.N1(8),  .N2(5))  dut_b_i (.a(a8),  .b(b5),  .product(p85));
  mult_csa #(.N1(2),  .N2(4))  dut_d_i (.a(a2),  .b(b4),  .product(p24));
  mult_csa #(.N1(12), .N2(10)) dut_c_i (.a(a12), .b(b10), .product(p1210));

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive_all(longint x6, longint y6, longint x8, longint y5,
                           longint x2, longint y4, longint x12, longint y10);
    @(negedge clk);
    a6 = 6'(x6); b6 = 6'(y6); a8 = 8'(x8); b5 = 5'(y5);
    a2 = 2'(x2); b4 = 4'(y4); a12 = 12'(x12); b10 = 10'(y10);
    #1;
  endtask

  initial begin
    a6 = '0; b6 = '0; a8 = '0; b5 = '0; a2 = '0; b4 = '0; a12 = '0; b10 = '0;
    repeat (2) @(negedge clk);
    #1;
    // R2: zero operands at start
    chk("R2 zero 6x6", p6, 0);
    chk("R2 zero 12x10", p1210, 0);

    // R3: all ones on every configuration
    drive_all(63, 63, 255, 31, 3, 15, 4095, 1023);
    chk("R3 ones 6x6", p6, 63 * 63);
    chk("R3 ones 8x5", p85, 255 * 31);
    chk("R3 ones 2x4", p24, 3 * 15);
    chk("R3 ones 12x10", p1210, 4095 * 1023);

    // R2: one side zero, other all ones
    drive_all(0, 63, 255, 0, 0, 15, 4095, 0);
    chk("R2 a zero 6x6", p6, 0);
    chk("R2 b zero 8x5", p85, 0);
    chk("R2 a zero 2x4", p24, 0);
    chk("R2 b zero 12x10", p1210, 0);

    // R4: single multiplier bit places b at offset i
    for (int i = 0; i < 12; i++) begin
      drive_all(64'(1) << (i % 6), 45, 64'(1) << (i % 8), 27, 64'(1) << (i % 2), 11,
                64'(1) << i, 1023);
      chk("R4 single bit 6x6", p6, 45 << (i % 6));
      chk("R4 single bit 8x5", p85, 27 << (i % 8));
      chk("R4 single bit 12x10", p1210, 1023 << i);
    end

    // R1 R8: exhaustive 6x6, operands change every cycle
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++) begin
        drive_all(x, y, 0, 0, 0, 0, 0, 0);
        chk("R1 R8 exhaustive 6x6", p6, x * y);
      end

    // R7: exhaustive unequal widths, including the two-row build
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 32; y++) begin
        drive_all(0, 0, x, y, x % 4, y % 16, 0, 0);
        chk("R7 exhaustive 8x5", p85, x * y);
        if (x < 4 && y < 16) chk("R7 exhaustive 2x4", p24, (x % 4) * (y % 16));
      end

    // R7 R1: random vectors at 12x10
    for (int n = 0; n < 3000; n++) begin
      longint x, y;
      x = longint'($urandom_range(4095, 0));
      y = longint'($urandom_range(1023, 0));
      drive_all(0, 0, 0, 0, 0, 0, x, y);
      chk("R7 random 12x10", p1210, x * y);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule